// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block turns a fast core clock into the serial clock of an SPI master. A prescale byte from a configuration register sets the divisor. A strap input picks one of two ways to read that byte. The legacy encoding reads a 5-bit field as an even divisor. The extended encoding reads a 4-bit factor and a 3-bit power-of-two exponent and multiplies them, which gives divisors up to 1920. Software works out the best setting for a requested baud rate. The block only carries out the setting it is given.

While `run` is high, the block drives `sck` through full periods. Each period starts with the clock at its idle (CPOL) level and then spends a phase at the opposite level. A one-cycle strobe marks the first core cycle of each active phase, and a second strobe marks the first core cycle back at the idle level. A shift engine can use these strobes as its leading and trailing edges. When `run` drops, or the decoded divisor changes, the phase counter starts again from the beginning of an idle phase. This means no shortened pulse ever reaches the pin.

Top module: `spi_sck_prescaler`

## Requirements
- R1: With `ext_mode`=0, the field is `prescale[4:0]` and the divisor is 2×(field−16). Field values 18 to 31 give the even divisors 4 to 30.
- R2: With `ext_mode`=0, a field value below 18 gives divisor 4, and `prescale[7:5]` has no effect on the divisor.
- R3: With `ext_mode`=1, the factor is `prescale[3:0]` and the exponent is {`prescale[7]`,`prescale[6]`,`prescale[4]`}. The divisor is factor×2^exponent, so byte 0xDF gives 1920. `prescale[5]` has no effect.
- R4: With `ext_mode`=1, a product below 4 gives divisor 4. This includes a factor of 0.
- R5: One SCK period lasts exactly divisor core cycles. The idle-level phase lasts floor(divisor/2) cycles and the active-level phase lasts ceil(divisor/2) cycles, so the active phase gets the extra cycle when the divisor is odd.
- R6: While `run` is low, and in the cycle after `run` was sampled low, `sck` equals `cpol` and neither strobe is asserted.
- R7: `sck_lead` is a one-cycle pulse in the first core cycle that `sck` sits at the active level (`sck` != `cpol`). `sck_trail` is a one-cycle pulse in the first core cycle that `sck` is back at `cpol`. The two strobes are never high together.
- R8: When `run` rises with the prescale setting already held for at least two cycles, the first `sck_lead` comes on the floor(divisor/2)-th clock edge sampled with `run` high. No clock edge comes earlier.
- R9: When the decoded divisor changes while running, `sck` returns to `cpol` on the next edge with no strobe. The first `sck_lead` then follows floor(newdivisor/2)+1 edges after the change.
- R10: During reset, `sck` equals `cpol` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Encoding strap: 0 legacy, 1 extended |
| prescale | input | 8 | Prescale byte from the configuration register |
| run | input | 1 | High to generate SCK, low to idle |
| cpol | input | 1 | Idle level of SCK |
| sck | output | 1 | Serial clock |
| sck_lead | output | 1 | Strobe in the first cycle of each active phase |
| sck_trail | output | 1 | Strobe in the first cycle of each idle phase |

## Verification
The legacy encoding is tried with the smallest divisor (4) and the largest (30) and a middle value. It is also tried with low field values and with junk in the upper bits, which shows whether the clamp works and whether the unused bits are truly ignored. The extended encoding is tried with each exponent bit set alone and with the all-ones byte that gives 1920. These cases show whether the split exponent bits are wired to the right weights. Factors 0, 1 and 3 check the clamp, and bit 5 set checks that it has no effect. Odd divisors 5, 7 and 15 show whether the extra cycle goes to the active phase. A divisor change in the middle of a period and a drop of `run` during the active phase check the restart rules, and reset is checked with both idle levels.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
    localparam int FACTOR_W = 4;
    localparam int EXP_W    = 3;
    localparam int LEG_W    = 5;
    localparam int MIN_DIV  = 4;
    // widest product: factor of FACTOR_W bits shifted by up to 2^EXP_W-1
    localparam int DIV_W    = FACTOR_W + (1 << EXP_W) - 1;

    typedef enum logic {
        ENC_LEGACY   = 1'b0,
        ENC_EXTENDED = 1'b1
    } enc_e;
endpackage

// File: rtl/sckdiv_decode.sv
module sckdiv_decode
    import sckdiv_pkg::*;
#(
    parameter int DW      = DIV_W,
    parameter int FW      = FACTOR_W,
    parameter int LW      = LEG_W,
    parameter int MINDIV  = MIN_DIV
) (
    input  enc_e          mode,
    input  logic [7:0]    pbyte,
    output logic [DW-1:0] divisor
);
    localparam logic [DW-1:0] LEG_BASE = DW'(1 << (LW - 1));
    localparam logic [DW-1:0] FLOOR    = DW'(MINDIV);

    logic [DW-1:0] leg_field;
    logic [DW-1:0] leg_raw;
    logic [FW-1:0] factor;
    logic [2:0]    expo;
    logic [DW-1:0] ext_raw;
    logic [DW-1:0] raw;
    logic          unused_gap_bit;

    assign unused_gap_bit = pbyte[5];

    always_comb begin
        // legacy: base-offset field, two core cycles per step
        leg_field = DW'(pbyte[LW-1:0]);
        if (leg_field >= LEG_BASE)
            leg_raw = (leg_field - LEG_BASE) << 1;
        else
            leg_raw = '0;

        // extended: exponent LSB sits at bit 4, upper bits at 7:6, bit 5 skipped
        factor  = pbyte[FW-1:0];
        expo    = {pbyte[7], pbyte[6], pbyte[4]};
        ext_raw = DW'(factor) << expo;

        raw     = (mode == ENC_EXTENDED) ? ext_raw : leg_raw;
        divisor = (raw < FLOOR) ? FLOOR : raw;
    end
endmodule

// File: rtl/sckdiv_phase.sv
module sckdiv_phase #(
    parameter int DW = sckdiv_pkg::DIV_W
) (
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] act_len,
    output logic [DW-1:0] idle_len
);
    // the active phase takes the odd cycle
    always_comb begin
        idle_len = divisor >> 1;
        act_len  = divisor - idle_len;
    end
endmodule

// File: rtl/sckdiv_timer.sv
module sckdiv_timer #(
    parameter int DW     = sckdiv_pkg::DIV_W,
    parameter int MINDIV = sckdiv_pkg::MIN_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] divisor,
    input  logic [DW-1:0] act_len,
    input  logic [DW-1:0] idle_len,
    output logic          active,
    output logic          lead,
    output logic          trail
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          active;
        logic          lead;
        logic          trail;
        logic [DW-1:0] div;
    } tmr_t;

    localparam logic [DW-1:0] ONE = DW'(1);

    tmr_t s_d, s_q;
    logic reload;

    always_comb begin
        s_d       = s_q;
        s_d.lead  = 1'b0;
        s_d.trail = 1'b0;
        s_d.div   = divisor;
        reload    = !run || (divisor != s_q.div);
        if (reload) begin
            s_d.cnt    = '0;
            s_d.active = 1'b0;
        end else if (!s_q.active && s_q.cnt == idle_len - ONE) begin
            s_d.cnt    = '0;
            s_d.active = 1'b1;
            s_d.lead   = 1'b1;
        end else if (s_q.active && s_q.cnt == act_len - ONE) begin
            s_d.cnt    = '0;
            s_d.active = 1'b0;
            s_d.trail  = 1'b1;
        end else begin
            s_d.cnt    = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, active: 1'b0, lead: 1'b0, trail: 1'b0,
                     div: DW'(MINDIV)};
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.active;
    assign lead   = s_q.lead;
    assign trail  = s_q.trail;

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_q.lead, s_q.trail}));

    assert_lead_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lead |-> (s_q.active && !$past(s_q.active)));

    assert_trail_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trail |-> (!s_q.active && $past(s_q.active)));

    assert_act_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && divisor == s_q.div) |-> (s_q.cnt < act_len));

    assert_idle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && divisor == s_q.div) |-> (s_q.cnt < idle_len));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && divisor != s_q.div) |=> (s_q.cnt == '0 && !s_q.active && !s_q.lead));
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
    import sckdiv_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_mode,
    input  logic [7:0] prescale,
    input  logic       run,
    input  logic       cpol,
    output logic       sck,
    output logic       sck_lead,
    output logic       sck_trail
);
    logic [DW-1:0] divisor;
    logic [DW-1:0] act_len;
    logic [DW-1:0] idle_len;
    logic          active;

    sckdiv_decode #(.DW(DW)) u_decode (
        .mode    (enc_e'(ext_mode)),
        .pbyte   (prescale),
        .divisor (divisor)
    );

    sckdiv_phase #(.DW(DW)) u_phase (
        .divisor  (divisor),
        .act_len  (act_len),
        .idle_len (idle_len)
    );

    sckdiv_timer #(.DW(DW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .divisor  (divisor),
        .act_len  (act_len),
        .idle_len (idle_len),
        .active   (active),
        .lead     (sck_lead),
        .trail    (sck_trail)
    );

    assign sck = cpol ^ active;

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sck == cpol && !sck_lead && !sck_trail));

    assert_lead_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sck_lead |-> (sck != cpol));
endmodule

// File: tb/sim_spi_sck_prescaler.sv
`timescale 1ns/100ps
module sim_spi_sck_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0;
    logic [7:0] prescale = 8'h12;
    logic       run = 1'b0;
    logic       cpol = 1'b1;
    logic       sck, sck_lead, sck_trail;
    int         total = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    spi_sck_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .prescale(prescale),
        .run(run), .cpol(cpol), .sck(sck), .sck_lead(sck_lead), .sck_trail(sck_trail)
    );

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    // R10: state held in reset
    task automatic t_reset();
        cpol = 1'b1; run = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 sck at cpol=1 in reset", sck, 1);
        chk("R10 strobes low in reset", {30'd0, sck_lead, sck_trail}, 0);
        cpol = 1'b0;
        @(negedge clk);
        chk("R10 sck at cpol=0 in reset", sck, 0);
        run = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // startup delay, active/idle lengths and level during one period
    task automatic t_period(input string req, input logic m, input logic [7:0] pb,
                            input logic cp, input int exp_act, input int exp_idle);
        int k, h, l, bad;
        run = 1'b0; ext_mode = m; prescale = pb; cpol = cp;
        repeat (3) @(negedge clk);
        run = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!sck_lead && k < 5000);
        chk({req, " R8 first lead delay"}, k, exp_idle);
        bad = 0; h = 1;
        if (sck != ~cp) bad++;
        forever begin
            @(negedge clk);
            if (sck_trail || h > 5000) break;
            if (sck != ~cp) bad++;
            h++;
        end
        l = 1;
        if (sck != cp) bad++;
        forever begin
            @(negedge clk);
            if (sck_lead || l > 5000) break;
            if (sck != cp) bad++;
            l++;
        end
        chk({req, " R5 active phase cycles"}, h, exp_act);
        chk({req, " R5 idle phase cycles"}, l, exp_idle);
        chk({req, " R7 sck level vs strobes"}, bad, 0);
        run = 1'b0;
        @(negedge clk);
    endtask

    // R6: idle level while run low, and drop of run in the active phase
    task automatic t_idle();
        int bad;
        bad = 0;
        run = 1'b0; ext_mode = 1'b0; prescale = 8'h12;
        cpol = 1'b1;
        repeat (4) begin @(negedge clk); if (sck != 1'b1 || sck_lead || sck_trail) bad++; end
        cpol = 1'b0;
        repeat (4) begin @(negedge clk); if (sck != 1'b0 || sck_lead || sck_trail) bad++; end
        chk("R6 sck follows cpol with run low", bad, 0);
        run = 1'b1;
        do @(negedge clk); while (!sck_lead);
        chk("R6 active before drop", sck, 1);
        run = 1'b0;
        @(negedge clk);
        chk("R6 sck back to cpol after run drop", sck, 0);
        chk("R6 no trail strobe after run drop", sck_trail, 0);
    endtask

    // R9: divisor change mid-run restarts the period
    task automatic t_change();
        int k;
        run = 1'b0; ext_mode = 1'b0; prescale = 8'h12; cpol = 1'b0;
        repeat (3) @(negedge clk);
        run = 1'b1;
        do @(negedge clk); while (!sck_lead);
        prescale = 8'h15;  // legacy divisor 10, idle phase 5
        @(negedge clk);
        chk("R9 sck idle right after change", sck, 0);
        chk("R9 no strobe right after change", {30'd0, sck_lead, sck_trail}, 0);
        k = 1;
        do begin @(negedge clk); k++; end while (!sck_lead && k < 100);
        chk("R9 first lead after change", k, 6);
        run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(150000 * 5);
        fails++; total++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        // legacy encoding
        t_period("R1 legacy 0x12 div4",   1'b0, 8'h12, 1'b0, 2, 2);
        t_period("R1 legacy 0x1F div30",  1'b0, 8'h1F, 1'b0, 15, 15);
        t_period("R1 legacy 0x15 div10",  1'b0, 8'h15, 1'b1, 5, 5);
        t_period("R2 legacy 0x05 clamp",  1'b0, 8'h05, 1'b0, 2, 2);
        t_period("R2 legacy 0x11 clamp",  1'b0, 8'h11, 1'b1, 2, 2);
        t_period("R2 legacy 0xF5 upper ignored", 1'b0, 8'hF5, 1'b0, 5, 5);
        // extended encoding
        t_period("R3 ext 0x1F div30",     1'b1, 8'h1F, 1'b0, 15, 15);
        t_period("R3 ext 0x43 div12",     1'b1, 8'h43, 1'b1, 6, 6);
        t_period("R3 ext 0x83 div48",     1'b1, 8'h83, 1'b0, 24, 24);
        t_period("R3 ext 0xDF div1920",   1'b1, 8'hDF, 1'b0, 960, 960);
        t_period("R3 ext 0x27 bit5 ignored div7", 1'b1, 8'h27, 1'b1, 4, 3);
        t_period("R4 ext 0x00 clamp",     1'b1, 8'h00, 1'b0, 2, 2);
        t_period("R4 ext 0x01 clamp",     1'b1, 8'h01, 1'b1, 2, 2);
        t_period("R4 ext 0x03 clamp",     1'b1, 8'h03, 1'b0, 2, 2);
        t_period("R5 ext 0x05 div5 odd",  1'b1, 8'h05, 1'b0, 3, 2);
        t_period("R5 ext 0x0F div15 odd", 1'b1, 8'h0F, 1'b1, 8, 7);
        t_change();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule